// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

This block carries one data word from a producer running on one clock to a consumer running on a second, unrelated clock, without passing through any queue. The producer stores a word with a qualified write. The word then stays in a holding register until the consumer takes it with a qualified read. A pending-mail flag, active LOW, is presented in both clock domains. While mail is pending, the producer may not write again.

The write and read events cross between the domains as level toggles. Each toggle passes through a multi-flop synchroniser. Each domain derives its own view of the flag by comparing its local toggle with the synchronised toggle from the other side. The consumer recognises a mailbox read from its transfer-size code, and the code 2'b11 selects the mailbox. An optional output tells a neighbouring parity block that a mailbox read with parity generation is set up, so that the neighbour forces its parity-error indication inactive.

Top module: `mbx_bypass`

## Requirements
- R1: After reset, `w_mail_n` and `r_mail_n` are both 1 (empty) and `r_data` is 0.
- R2: A write is accepted on a rising `w_clk` edge when `w_sel_n`=0, `w_en`=1, `w_write`=1, `w_mbox`=1 and `w_mail_n`=1. `w_mail_n` is 0 directly after that edge.
- R3: A write attempt in which any one of `w_sel_n`=0, `w_en`=1, `w_write`=1 or `w_mbox`=1 does not hold has no effect. Both flags stay 1.
- R4: While `w_mail_n`=0, write attempts are ignored. The stored word is unchanged and the flag stays 0.
- R5: After an accepted write, `r_mail_n` falls to 0 within 4 rising `r_clk` edges.
- R6: A read is accepted on a rising `r_clk` edge when `r_sel_n`=0, `r_en`=1, `r_write`=0, `r_size`=2'b11 and `r_mail_n`=0. `r_mail_n` is 1 directly after that edge, and `r_data` equalled the written word before it.
- R7: A read attempt with `r_size` other than 2'b11, or with `r_sel_n`=1, `r_en`=0 or `r_write`=1, leaves `r_mail_n` at 0.
- R8: After an accepted read, `w_mail_n` returns to 1 within 4 rising `w_clk` edges, and a new write is then accepted.
- R9: `r_par_force` is 1 exactly when `r_pgen`=1, `r_write`=0 and `r_size`=2'b11. This holds regardless of select, enable and flag.
- R10: A qualified read while `r_mail_n`=1 is ignored. Both flags stay 1, and the next write is read exactly once.
- R11: `r_data` does not change while `r_mail_n` stays 0.
- R12: With the two clocks unrelated, every accepted write is read exactly once and in order, and no word is lost or overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_clk | input | 1 | Producer clock |
| r_clk | input | 1 | Consumer clock |
| rst_n | input | 1 | Asynchronous reset, active LOW, both domains |
| w_sel_n | input | 1 | Producer select, active LOW |
| w_en | input | 1 | Producer enable |
| w_write | input | 1 | Producer direction, 1 = write |
| w_mbox | input | 1 | Producer mailbox select |
| w_data | input | 36 | Word to store |
| w_mail_n | output | 1 | Mail pending, producer view, active LOW |
| r_sel_n | input | 1 | Consumer select, active LOW |
| r_en | input | 1 | Consumer enable |
| r_write | input | 1 | Consumer direction, 0 = read |
| r_size | input | 2 | Consumer size code, 2'b11 = mailbox |
| r_pgen | input | 1 | Consumer parity generation request |
| r_data | output | 36 | Stored mailbox word |
| r_mail_n | output | 1 | Mail pending, consumer view, active LOW |
| r_par_force | output | 1 | Mailbox read with parity generation is set up |

## Verification
Writes are tried with each qualifier missing in turn and while mail is pending. This separates a correct qualifier decode and write blocking from a design that stores too eagerly. Reads are tried with each non-mailbox size code, with each qualifier off, and against an empty mailbox. This shows that only the exact mailbox read clears the flag. A free-running phase with unrelated clock periods, random-length consumer delays and junk writes while mail is pending ties every accepted word to exactly one read through a queue. This exposes lost, duplicated or overwritten words in the toggle handshake.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // size code on the consumer side that addresses the mailbox
    localparam logic [1:0] MBX_SIZE_CODE = 2'b11;

    function automatic logic wr_hit(input logic sel_n, input logic en,
                                    input logic write, input logic mbox);
        return (~sel_n) & en & write & mbox;
    endfunction

    function automatic logic rd_hit(input logic sel_n, input logic en,
                                    input logic write, input logic [1:0] size);
        return (~sel_n) & en & (~write) & (size == MBX_SIZE_CODE);
    endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d;
        end else begin : g_many
            always_comb chain_d = {chain_q[LAST-1:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[LAST];

    initial begin
        if (STAGES < 2) $error("mbx_sync: STAGES below 2 is not metastability safe");
    end
endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side
    import mbx_pkg::*;
#(
    parameter int DW          = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          en,
    input  logic          write,
    input  logic          mbox,
    input  logic [DW-1:0] data_i,
    input  logic          rtog_i,
    output logic          wtog_o,
    output logic [DW-1:0] data_o,
    output logic          mail_n_o
);
    typedef struct packed {
        logic          tog;
        logic [DW-1:0] word;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic      rtog_s;
    logic      pending;
    logic      accept;

    mbx_sync #(.STAGES(SYNC_STAGES)) i_rtog_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rtog_i),
        .q     (rtog_s)
    );

    always_comb begin
        pending = st_q.tog ^ rtog_s;
        accept  = wr_hit(sel_n, en, write, mbox) & ~pending;
        st_d    = st_q;
        if (accept) begin
            st_d.tog  = ~st_q.tog;
            st_d.word = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wtog_o   = st_q.tog;
    assign data_o   = st_q.word;
    assign mail_n_o = ~pending;

    // R2: an accepted write shows mail pending right after the edge
    p_flag_low_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !mail_n_o);

    // R4: nothing overwrites the stored word while mail is pending
    p_word_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mail_n_o |=> $stable(data_o));
endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side
    import mbx_pkg::*;
#(
    parameter int DW          = 36,
    parameter int SYNC_STAGES = 2,
    parameter bit PAR_HOOK    = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          en,
    input  logic          write,
    input  logic [1:0]    size,
    input  logic          pgen,
    input  logic          wtog_i,
    input  logic [DW-1:0] data_i,
    output logic          rtog_o,
    output logic [DW-1:0] data_o,
    output logic          mail_n_o,
    output logic          par_force_o
);
    typedef struct packed {
        logic tog;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      wtog_s;
    logic      pending;
    logic      accept;

    mbx_sync #(.STAGES(SYNC_STAGES)) i_wtog_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wtog_i),
        .q     (wtog_s)
    );

    always_comb begin
        pending = wtog_s ^ st_q.tog;
        accept  = rd_hit(sel_n, en, write, size) & pending;
        st_d    = st_q;
        if (accept) st_d.tog = ~st_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (PAR_HOOK) begin : g_par_hook
            assign par_force_o = pgen & ~write & (size == MBX_SIZE_CODE);
        end else begin : g_no_par_hook
            assign par_force_o = 1'b0;
        end
    endgenerate

    assign rtog_o   = st_q.tog;
    assign data_o   = data_i;
    assign mail_n_o = ~pending;

    // R6: an accepted read empties the consumer view right after the edge
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> mail_n_o);

    // R11: the word seen by the consumer is stable while mail stays pending
    p_data_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mail_n_o && $past(!mail_n_o)) |-> $stable(data_i));

    // R10: with no mail pending the consumer toggle does not move
    p_empty_read_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mail_n_o |=> $stable(rtog_o));
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass #(
    parameter int DW          = 36,
    parameter int SYNC_STAGES = 2,
    parameter bit PAR_HOOK    = 1'b1
) (
    input  logic          w_clk,
    input  logic          r_clk,
    input  logic          rst_n,
    input  logic          w_sel_n,
    input  logic          w_en,
    input  logic          w_write,
    input  logic          w_mbox,
    input  logic [DW-1:0] w_data,
    output logic          w_mail_n,
    input  logic          r_sel_n,
    input  logic          r_en,
    input  logic          r_write,
    input  logic [1:0]    r_size,
    input  logic          r_pgen,
    output logic [DW-1:0] r_data,
    output logic          r_mail_n,
    output logic          r_par_force
);
    logic          wtog;
    logic          rtog;
    logic [DW-1:0] word;

    mbx_wr_side #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) i_wr (
        .clk      (w_clk),
        .rst_n    (rst_n),
        .sel_n    (w_sel_n),
        .en       (w_en),
        .write    (w_write),
        .mbox     (w_mbox),
        .data_i   (w_data),
        .rtog_i   (rtog),
        .wtog_o   (wtog),
        .data_o   (word),
        .mail_n_o (w_mail_n)
    );

    mbx_rd_side #(.DW(DW), .SYNC_STAGES(SYNC_STAGES), .PAR_HOOK(PAR_HOOK)) i_rd (
        .clk         (r_clk),
        .rst_n       (rst_n),
        .sel_n       (r_sel_n),
        .en          (r_en),
        .write       (r_write),
        .size        (r_size),
        .pgen        (r_pgen),
        .wtog_i      (wtog),
        .data_i      (word),
        .rtog_o      (rtog),
        .data_o      (r_data),
        .mail_n_o    (r_mail_n),
        .par_force_o (r_par_force)
    );
endmodule

// File: tb/test_mbx_bypass.sv
`timescale 1ns/100ps
module test_mbx_bypass;
    localparam int DW = 36;
    localparam int NWORDS = 24;

    logic          w_clk = 1'b0, r_clk = 1'b0, rst_n = 1'b0;
    logic          w_sel_n = 1'b1, w_en = 1'b0, w_write = 1'b0, w_mbox = 1'b0;
    logic [DW-1:0] w_data = '0;
    logic          w_mail_n;
    logic          r_sel_n = 1'b1, r_en = 1'b0, r_write = 1'b1, r_pgen = 1'b0;
    logic [1:0]    r_size = 2'b00;
    logic [DW-1:0] r_data;
    logic          r_mail_n, r_par_force;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_q[$];

    always #2.5 w_clk = ~w_clk;
    always #3.5 r_clk = ~r_clk;

    mbx_bypass i_mbx_bypass (
        .w_clk(w_clk), .r_clk(r_clk), .rst_n(rst_n),
        .w_sel_n(w_sel_n), .w_en(w_en), .w_write(w_write), .w_mbox(w_mbox),
        .w_data(w_data), .w_mail_n(w_mail_n),
        .r_sel_n(r_sel_n), .r_en(r_en), .r_write(r_write), .r_size(r_size),
        .r_pgen(r_pgen), .r_data(r_data), .r_mail_n(r_mail_n),
        .r_par_force(r_par_force)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // caller stands at a negedge of w_clk
    task automatic do_write(input logic [DW-1:0] d, input logic s, input logic e,
                            input logic w, input logic m);
        w_data = d; w_sel_n = s; w_en = e; w_write = w; w_mbox = m;
        @(negedge w_clk);
        w_sel_n = 1'b1; w_en = 1'b0; w_write = 1'b0; w_mbox = 1'b0;
    endtask

    // caller stands at a negedge of r_clk
    task automatic do_read(input logic s, input logic e, input logic w,
                           input logic [1:0] z);
        r_sel_n = s; r_en = e; r_write = w; r_size = z;
        @(negedge r_clk);
        r_sel_n = 1'b1; r_en = 1'b0; r_write = 1'b1; r_size = 2'b00;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        int n;
        #61 rst_n = 1'b1;
        @(negedge w_clk);
        chk(w_mail_n == 1'b1, "R1 w_mail_n after reset", DW'(w_mail_n), 1);
        chk(r_mail_n == 1'b1, "R1 r_mail_n after reset", DW'(r_mail_n), 1);
        chk(r_data == '0, "R1 r_data after reset", r_data, '0);

        // R3: each qualifier missing in turn
        for (int k = 0; k < 4; k++) begin
            @(negedge w_clk);
            do_write(36'hBAD00000 + DW'(k), k == 0, k != 1, k != 2, k != 3);
            chk(w_mail_n == 1'b1, "R3 unqualified write", DW'(w_mail_n), 1);
        end
        repeat (6) @(negedge r_clk);
        chk(r_mail_n == 1'b1, "R3 reader still empty", DW'(r_mail_n), 1);

        // R10: read of an empty mailbox
        @(negedge r_clk);
        do_read(1'b0, 1'b1, 1'b0, 2'b11);
        chk(r_mail_n == 1'b1, "R10 empty read reader flag", DW'(r_mail_n), 1);
        repeat (6) @(negedge w_clk);
        chk(w_mail_n == 1'b1, "R10 empty read writer flag", DW'(w_mail_n), 1);

        // R2 / R5
        @(negedge w_clk);
        do_write(36'h123456789, 1'b0, 1'b1, 1'b1, 1'b1);
        chk(w_mail_n == 1'b0, "R2 flag low after write", DW'(w_mail_n), 0);
        n = 0;
        @(negedge r_clk);
        while (r_mail_n && n < 4) begin @(negedge r_clk); n++; end
        chk(r_mail_n == 1'b0, "R5 reader sees mail", DW'(r_mail_n), 0);

        // R4: write while pending
        @(negedge w_clk);
        do_write(36'hFFFFFFFFF, 1'b0, 1'b1, 1'b1, 1'b1);
        chk(w_mail_n == 1'b0, "R4 flag stays low", DW'(w_mail_n), 0);
        repeat (3) @(negedge r_clk);
        chk(r_data == 36'h123456789, "R4 word not overwritten", r_data, 36'h123456789);

        // R7: non-mailbox reads
        for (int k = 0; k < 6; k++) begin
            @(negedge r_clk);
            case (k)
                0: do_read(1'b0, 1'b1, 1'b0, 2'b00);
                1: do_read(1'b0, 1'b1, 1'b0, 2'b01);
                2: do_read(1'b0, 1'b1, 1'b0, 2'b10);
                3: do_read(1'b1, 1'b1, 1'b0, 2'b11);
                4: do_read(1'b0, 1'b0, 1'b0, 2'b11);
                default: do_read(1'b0, 1'b1, 1'b1, 2'b11);
            endcase
            chk(r_mail_n == 1'b0, "R7 read without clear", DW'(r_mail_n), 0);
        end
        chk(r_data == 36'h123456789, "R11 word stable while pending", r_data, 36'h123456789);

        // R9: parity hook
        @(negedge r_clk);
        r_write = 1'b0; r_size = 2'b11; r_pgen = 1'b1; #1;
        chk(r_par_force == 1'b1, "R9 hook on", DW'(r_par_force), 1);
        r_pgen = 1'b0; #1;
        chk(r_par_force == 1'b0, "R9 hook off without pgen", DW'(r_par_force), 0);
        r_pgen = 1'b1; r_size = 2'b10; #1;
        chk(r_par_force == 1'b0, "R9 hook off wrong size", DW'(r_par_force), 0);
        r_size = 2'b11; r_write = 1'b1; #1;
        chk(r_par_force == 1'b0, "R9 hook off on write", DW'(r_par_force), 0);
        r_pgen = 1'b0; r_size = 2'b00;

        // R6 / R8
        @(negedge r_clk);
        chk(r_data == 36'h123456789, "R6 data before read", r_data, 36'h123456789);
        do_read(1'b0, 1'b1, 1'b0, 2'b11);
        chk(r_mail_n == 1'b1, "R6 flag high after read", DW'(r_mail_n), 1);
        n = 0;
        @(negedge w_clk);
        while (!w_mail_n && n < 4) begin @(negedge w_clk); n++; end
        chk(w_mail_n == 1'b1, "R8 writer flag recovers", DW'(w_mail_n), 1);
        do_write(36'h0A5A5A5A5, 1'b0, 1'b1, 1'b1, 1'b1);
        chk(w_mail_n == 1'b0, "R8 new write accepted", DW'(w_mail_n), 0);
        n = 0;
        @(negedge r_clk);
        while (r_mail_n && n < 4) begin @(negedge r_clk); n++; end
        chk(r_data == 36'h0A5A5A5A5, "R8 new word delivered", r_data, 36'h0A5A5A5A5);
        do_read(1'b0, 1'b1, 1'b0, 2'b11);
        repeat (8) @(negedge w_clk);

        // R12: scoreboard with unrelated clocks
        fork
            begin : writer
                int i = 0;
                while (i < NWORDS) begin
                    @(negedge w_clk);
                    if (!w_mail_n) begin
                        do_write(36'hDEAD00000 + DW'(i), 1'b0, 1'b1, 1'b1, 1'b1);
                    end else begin
                        logic [DW-1:0] v;
                        v = {4'(i), 32'(i * 32'h9E3779B1)};
                        exp_q.push_back(v);
                        do_write(v, 1'b0, 1'b1, 1'b1, 1'b1);
                        i++;
                    end
                end
            end
            begin : reader
                int got = 0;
                while (got < NWORDS) begin
                    @(negedge r_clk);
                    if (!r_mail_n) begin
                        logic [DW-1:0] e;
                        repeat (got % 4) @(negedge r_clk);
                        e = (exp_q.size() != 0) ? exp_q.pop_front() : '1;
                        chk(r_data == e, "R12 word in order", r_data, e);
                        do_read(1'b0, 1'b1, 1'b0, 2'b11);
                        got++;
                    end
                end
            end
        join
        repeat (10) @(negedge r_clk);
        chk(exp_q.size() == 0, "R12 no word left unread", DW'(exp_q.size()), 0);
        chk(r_mail_n == 1'b1, "R12 no extra mail pending", DW'(r_mail_n), 1);
        @(negedge w_clk);
        chk(w_mail_n == 1'b1, "R12 writer flag empty at end", DW'(w_mail_n), 1);
        finish_run();
    end
endmodule